// File: doc/BRIEF.md
# Configuration Cache Write Port

This block sits on a microcontroller's I/O register bus and gives the processor a path for pushing single bytes into the configuration cache of a reconfigurable fabric. Three byte-wide address registers, each readable and writable by the processor, are joined into a 24-bit cache address. The register at the lowest offset supplies the most significant byte.

A fourth I/O offset has no storage behind it. When the cache-interface enable input is high, an I/O write to that offset produces a cache write strobe one cycle long. The strobe comes out together with the written byte and a snapshot of the 24-bit address. When the enable is low, a write there does nothing. A read there returns zero.

Software loads the address once, then writes the data offset for each byte it pushes.

Top module: `cfg_cache_wport`

## Requirements
- R1: While `rst_ni` is low, and after it is released, the three address registers are 0x00, `cache_we_o` is 0, and `cache_data_o` and `cache_addr_o` are zero.
- R2: A write to offset 0x18, 0x19 or 0x1A stores `io_wdata_i` in the high, middle or low address register at the clock edge. A read (`io_rd_i` high) of that offset returns the stored byte on `io_rdata_o` in the same cycle.
- R3: `cache_addr_o` is {reg@0x18, reg@0x19, reg@0x1A}: offset 0x18 drives bits [23:16], 0x19 drives bits [15:8] and 0x1A drives bits [7:0].
- R4: A write to the data offset 0x1B with `cache_en_i` high raises `cache_we_o` in the cycle after the write's clock edge. It stays high for exactly one cycle per write.
- R5: During that strobe cycle, `cache_data_o` equals the byte written and `cache_addr_o` equals the address register contents at the write's clock edge.
- R6: A write to 0x1B with `cache_en_i` low produces no strobe, and `cache_data_o` and `cache_addr_o` keep their values.
- R7: A read of 0x1B, or of any offset outside 0x18 to 0x1B, returns 0x00 on `io_rdata_o` and produces no strobe. `io_rdata_o` is 0x00 whenever `io_rd_i` is low.
- R8: A write to an offset outside 0x18 to 0x1B changes no address register and produces no strobe.
- R9: A write to 0x1B leaves all three address registers unchanged.
- R10: Qualifying data writes on consecutive cycles produce strobes on consecutive cycles, each carrying its own byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| io_addr_i | input | 6 | I/O register offset |
| io_wr_i | input | 1 | I/O write enable, one cycle per write |
| io_rd_i | input | 1 | I/O read enable |
| io_wdata_i | input | 8 | I/O write data |
| io_rdata_o | output | 8 | I/O read data (combinational) |
| cache_en_i | input | 1 | Cache-interface enable |
| cache_we_o | output | 1 | Cache write strobe |
| cache_data_o | output | 8 | Byte presented to the cache |
| cache_addr_o | output | 24 | Cache address presented with the strobe |

## Verification
The hardest case to reach is a data write that lands in the cycle right after an address register is rewritten. The strobe must carry the new address, while the strobe of the previous data write, still on the outputs, keeps the old one. The vector table runs back-to-back data writes and then an address write followed at once by a data write, checking the outputs after every edge. A disabled data write placed between two enabled ones shows that the held byte and address do not move.

// File: rtl/cfg_cache_pkg.sv
package cfg_cache_pkg;
  localparam int unsigned IO_AW     = 6;
  localparam int unsigned DW        = 8;
  localparam int unsigned NREG      = 3;
  localparam int unsigned BASE_ADDR = 'h18;
endpackage

// File: rtl/cwp_decode.sv
module cwp_decode #(
  parameter int unsigned IO_AW     = 6,
  parameter int unsigned NREG      = 3,
  parameter int unsigned BASE_ADDR = 'h18
) (
  input  logic [IO_AW-1:0] addr_i,
  input  logic             wr_i,
  input  logic             rd_i,
  input  logic             en_i,
  output logic [NREG-1:0]  reg_we_o,
  output logic [NREG-1:0]  reg_rd_o,
  output logic             data_wr_o
);
  localparam logic [IO_AW-1:0] DATA_ADDR = IO_AW'(BASE_ADDR + NREG);

  for (genvar i = 0; i < NREG; i++) begin : g_sel
    localparam logic [IO_AW-1:0] REG_ADDR = IO_AW'(BASE_ADDR + i);
    assign reg_we_o[i] = wr_i && (addr_i == REG_ADDR);
    assign reg_rd_o[i] = rd_i && (addr_i == REG_ADDR);
  end

  // data offset is write-only; gated by the cache enable
  assign data_wr_o = wr_i && en_i && (addr_i == DATA_ADDR);
endmodule

// File: rtl/cwp_addr_regs.sv
module cwp_addr_regs #(
  parameter int unsigned DW   = 8,
  parameter int unsigned NREG = 3,
  localparam int unsigned AW  = DW * NREG
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NREG-1:0] we_i,
  input  logic [NREG-1:0] rd_i,
  input  logic [DW-1:0]   wdata_i,
  output logic [DW-1:0]   rdata_o,
  output logic [AW-1:0]   addr_o
);
  logic [DW-1:0] regs_q [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    regs_q[i] <= '0;
      else if (we_i[i]) regs_q[i] <= wdata_i;
    end
    // lowest offset lands in the most significant byte
    assign addr_o[(NREG-1-i)*DW +: DW] = regs_q[i];
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NREG; i++) begin
      if (rd_i[i]) rdata_o = rdata_o | regs_q[i];
    end
  end
endmodule

// File: rtl/cwp_strobe.sv
module cwp_strobe #(
  parameter int unsigned DW = 8,
  parameter int unsigned AW = 24
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          hit_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] addr_i,
  output logic          we_o,
  output logic [DW-1:0] data_o,
  output logic [AW-1:0] addr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_o   <= 1'b0;
      data_o <= '0;
      addr_o <= '0;
    end else begin
      we_o <= hit_i;
      if (hit_i) begin
        data_o <= wdata_i;
        addr_o <= addr_i;
      end
    end
  end
endmodule

// File: rtl/cfg_cache_wport.sv
module cfg_cache_wport
  import cfg_cache_pkg::*;
#(
  parameter int unsigned P_IO_AW = IO_AW,
  parameter int unsigned P_DW    = DW,
  parameter int unsigned P_NREG  = NREG,
  parameter int unsigned P_BASE  = BASE_ADDR,
  localparam int unsigned P_AW   = P_DW * P_NREG
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [P_IO_AW-1:0] io_addr_i,
  input  logic               io_wr_i,
  input  logic               io_rd_i,
  input  logic [P_DW-1:0]    io_wdata_i,
  output logic [P_DW-1:0]    io_rdata_o,
  input  logic               cache_en_i,
  output logic               cache_we_o,
  output logic [P_DW-1:0]    cache_data_o,
  output logic [P_AW-1:0]    cache_addr_o
);
  logic [P_NREG-1:0] reg_we, reg_rd;
  logic              data_wr;
  logic [P_AW-1:0]   addr_cur;

  cwp_decode #(.IO_AW(P_IO_AW), .NREG(P_NREG), .BASE_ADDR(P_BASE)) u_dec (
    .addr_i   (io_addr_i),
    .wr_i     (io_wr_i),
    .rd_i     (io_rd_i),
    .en_i     (cache_en_i),
    .reg_we_o (reg_we),
    .reg_rd_o (reg_rd),
    .data_wr_o(data_wr)
  );

  cwp_addr_regs #(.DW(P_DW), .NREG(P_NREG)) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (reg_we),
    .rd_i   (reg_rd),
    .wdata_i(io_wdata_i),
    .rdata_o(io_rdata_o),
    .addr_o (addr_cur)
  );

  cwp_strobe #(.DW(P_DW), .AW(P_AW)) u_stb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hit_i  (data_wr),
    .wdata_i(io_wdata_i),
    .addr_i (addr_cur),
    .we_o   (cache_we_o),
    .data_o (cache_data_o),
    .addr_o (cache_addr_o)
  );
endmodule

// File: rtl/cfg_cache_wport_chk.sv
module cfg_cache_wport_chk
  import cfg_cache_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic [IO_AW-1:0] io_addr_i,
  input logic             io_wr_i,
  input logic             io_rd_i,
  input logic [DW-1:0]    io_wdata_i,
  input logic [DW-1:0]    io_rdata_o,
  input logic             cache_en_i,
  input logic             cache_we_o,
  input logic [DW-1:0]    cache_data_o
);
  localparam logic [IO_AW-1:0] DATA_OFS = IO_AW'(BASE_ADDR + NREG);
  logic qual;
  assign qual = io_wr_i && cache_en_i && (io_addr_i == DATA_OFS);

  a_r4_strobe_after_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    qual |=> cache_we_o);
  a_r6_no_strobe_unqualified: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !qual |=> !cache_we_o);
  a_r5_data_forwarded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    qual |=> (cache_data_o == $past(io_wdata_i)));
  a_r6_data_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !qual |=> $stable(cache_data_o));
  a_r7_data_ofs_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_addr_i == DATA_OFS) |-> (io_rdata_o == '0));
  a_r7_idle_bus_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !io_rd_i |-> (io_rdata_o == '0));
endmodule

bind cfg_cache_wport cfg_cache_wport_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .io_addr_i   (io_addr_i),
  .io_wr_i     (io_wr_i),
  .io_rd_i     (io_rd_i),
  .io_wdata_i  (io_wdata_i),
  .io_rdata_o  (io_rdata_o),
  .cache_en_i  (cache_en_i),
  .cache_we_o  (cache_we_o),
  .cache_data_o(cache_data_o)
);

// File: tb/tb_cfg_cache_wport.sv
module tb_cfg_cache_wport;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  io_addr = '0;
  logic        io_wr = 1'b0, io_rd = 1'b0, cache_en = 1'b0;
  logic [7:0]  io_wdata = '0;
  logic [7:0]  io_rdata, cache_data;
  logic        cache_we;
  logic [23:0] cache_addr;

  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_cache_wport dut (
    .clk_i(clk), .rst_ni(rst_n), .io_addr_i(io_addr), .io_wr_i(io_wr),
    .io_rd_i(io_rd), .io_wdata_i(io_wdata), .io_rdata_o(io_rdata),
    .cache_en_i(cache_en), .cache_we_o(cache_we), .cache_data_o(cache_data),
    .cache_addr_o(cache_addr)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic        wr, rd, en;
    logic [5:0]  addr;
    logic [7:0]  wdata;
    logic [7:0]  x_rd;
    logic        x_we;
    logic [7:0]  x_dat;
    logic [23:0] x_adr;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t VECS [NV] = '{
    '{4'd2,  1,0,1,6'h18,8'hAB, 8'h00,0,8'h00,24'h000000}, // R2
    '{4'd2,  1,0,1,6'h19,8'hCD, 8'h00,0,8'h00,24'h000000}, // R2
    '{4'd2,  1,0,1,6'h1A,8'hEF, 8'h00,0,8'h00,24'h000000}, // R2
    '{4'd2,  0,1,1,6'h18,8'h00, 8'hAB,0,8'h00,24'h000000}, // R2
    '{4'd2,  0,1,1,6'h19,8'h00, 8'hCD,0,8'h00,24'h000000}, // R2
    '{4'd2,  0,1,1,6'h1A,8'h00, 8'hEF,0,8'h00,24'h000000}, // R2
    '{4'd3,  1,0,1,6'h1B,8'h5A, 8'h00,1,8'h5A,24'hABCDEF}, // R3 R4 R5
    '{4'd4,  0,0,1,6'h00,8'h00, 8'h00,0,8'h5A,24'hABCDEF}, // R4 single cycle
    '{4'd6,  1,0,0,6'h1B,8'h77, 8'h00,0,8'h5A,24'hABCDEF}, // R6
    '{4'd7,  0,1,1,6'h1B,8'h00, 8'h00,0,8'h5A,24'hABCDEF}, // R7
    '{4'd8,  1,0,1,6'h1C,8'h99, 8'h00,0,8'h5A,24'hABCDEF}, // R8
    '{4'd8,  1,0,1,6'h17,8'h11, 8'h00,0,8'h5A,24'hABCDEF}, // R8
    '{4'd7,  0,1,1,6'h1C,8'h00, 8'h00,0,8'h5A,24'hABCDEF}, // R7
    '{4'd7,  0,1,1,6'h17,8'h00, 8'h00,0,8'h5A,24'hABCDEF}, // R7
    '{4'd9,  0,1,1,6'h18,8'h00, 8'hAB,0,8'h5A,24'hABCDEF}, // R9
    '{4'd2,  1,0,1,6'h1A,8'h34, 8'h00,0,8'h5A,24'hABCDEF}, // R2
    '{4'd10, 1,0,1,6'h1B,8'h01, 8'h00,1,8'h01,24'hABCD34}, // R10
    '{4'd10, 1,0,1,6'h1B,8'h02, 8'h00,1,8'h02,24'hABCD34}, // R10
    '{4'd3,  1,0,1,6'h18,8'h00, 8'h00,0,8'h02,24'hABCD34}, // R3
    '{4'd5,  1,0,1,6'h1B,8'h03, 8'h00,1,8'h03,24'h00CD34}, // R5
    '{4'd6,  1,0,0,6'h1B,8'hEE, 8'h00,0,8'h03,24'h00CD34}, // R6
    '{4'd9,  0,1,1,6'h19,8'h00, 8'hCD,0,8'h03,24'h00CD34}, // R9
    '{4'd9,  0,1,1,6'h1A,8'h00, 8'h34,0,8'h03,24'h00CD34}  // R9
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic chk_reset_state(input string tag);
    chk({tag, " we"},   32'(cache_we),   32'd0);
    chk({tag, " data"}, 32'(cache_data), 32'd0);
    chk({tag, " addr"}, 32'(cache_addr), 32'd0);
    for (int a = 'h18; a <= 'h1A; a++) begin
      io_rd = 1'b1; io_addr = 6'(a); #1;
      chk({tag, " reg"}, 32'(io_rdata), 32'd0);
    end
    io_rd = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD*2 + 1);
    chk_reset_state("R1 in reset");
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk_reset_state("R1 after release");

    for (int i = 0; i < NV; i++) begin
      vec_t v = VECS[i];
      @(negedge clk);
      io_wr = v.wr; io_rd = v.rd; cache_en = v.en;
      io_addr = v.addr; io_wdata = v.wdata;
      #1;
      chk($sformatf("R%0d vec%0d rdata", v.req, i), 32'(io_rdata), 32'(v.x_rd));
      @(posedge clk); #1;
      io_wr = 1'b0; io_rd = 1'b0;
      chk($sformatf("R%0d vec%0d we", v.req, i),   32'(cache_we),   32'(v.x_we));
      chk($sformatf("R%0d vec%0d data", v.req, i), 32'(cache_data), 32'(v.x_dat));
      chk($sformatf("R%0d vec%0d addr", v.req, i), 32'(cache_addr), v.x_adr);
    end

    // R4: strobe drops after one cycle even with bus idle
    @(negedge clk);
    chk("R4 strobe ended", 32'(cache_we), 32'd0);
    // R7: idle bus reads zero even when addressing a register
    io_addr = 6'h19; #1;
    chk("R7 no read enable", 32'(io_rdata), 32'd0);

    // R1: reset mid-run clears everything
    @(negedge clk); rst_n = 1'b0; #1;
    chk_reset_state("R1 async reset");
    @(negedge clk); rst_n = 1'b1;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule